// File: doc/BRIEF.md
# Block-Granular Security Filter

This block stands between a bus master and a memory and filters every transfer against a table of security bits. Each bit covers one fixed, power-of-two sized block of the protected space. A transfer is forwarded only when its address falls in one of the protected ranges and its non-secure flag equals the bit of the block it targets. Any other transfer is blocked. A blocked transfer is answered in one of three ways, chosen by software: it completes quietly, with reads returning zero and writes dropped; it completes with an error; or it is held until software releases gating.

Software sets the block up through a small register port. It can fill the table through an index/data register pair whose index steps on its own. It can also pick the response mode, request that incoming traffic be stalled and wait for the acknowledge, enable an interrupt that flags violations, and read the address and direction of the first violation. A lockdown bit freezes the table and the control settings until the next reset. Several address ranges can be protected. Each range takes a contiguous slice of the table, placed after the slices of the ranges listed before it.

Transfers use a valid/ready handshake on both sides. Transfer data travels beside the handshake outside this block. A forwarded transfer takes its back-pressure from downstream: `up_ready` follows `dn_ready`. A blocked transfer answered quietly or with an error never waits on downstream. A blocked transfer in hold mode, or any transfer while gating is acknowledged, sees `up_ready` low. The master must keep `up_valid` and the transfer fields stable until it sees `up_ready` high.

Top module: `secblk_guard`

## Requirements
- R1: Each table bit covers one block of 2^BLK_SHIFT bytes (256 by default). A bit value of 1 means non-secure and 0 means secure. A transfer is forwarded (`dn_valid` high, `up_err` and `up_razwi` low) only when `up_nonsec` equals the bit of its block.
- R2: With the default parameters, range 0 spans 0x0000–0x1FFF and uses table bits 0–31. Range 1 spans 0x8000–0x9FFF and uses bits 32–63. An address outside every range is treated as a violation.
- R3: CTRL bits [2:1] select the violation response. 0 completes the transfer at once with `up_razwi` high. 1 or 3 completes it at once with `up_err` high. 2 holds it (`up_ready` low) while the gate request is set; once the request is clear it completes with `up_razwi` high.
- R4: CTRL bit 3 requests gating, and CTRL bit 5 (read-only) acknowledges it. The acknowledge rises only while no forwarded transfer is waiting on `dn_ready`. While it is high, `up_ready` and `dn_valid` are low. Clearing the request drops the acknowledge on the following clock.
- R5: Writing 1 to CTRL bit 4 locks the block. The lock stays set until reset. While locked, writes to CTRL, INDEX and DATA have no effect, but the interrupt status can still be cleared.
- R6: A violation that is not gated sets bit 0 of the status register (address 4). Writing 1 to that bit clears it. The `irq` pin is high when the status is set and CTRL bit 0 is set.
- R7: The capture register (address 5) holds the address of a violation in its low bits and the write flag in bit 31. It is loaded only while the status is clear.
- R8: INDEX (address 2) selects a 32-bit word of the table, and DATA (address 3) reads or writes that word. Each DATA access advances the index by one, wrapping after the last word.
- R9: After reset every block is secure, CTRL reads 0x40 (bit 6 shows that gating hardware is present), the status is clear, and address 1 reads the block size in bytes.
- R10: A forwarded transfer waits on downstream, so `up_ready` follows `dn_ready`. A transfer blocked with the quiet or error response completes even while `dn_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| up_valid | input | 1 | Master presents a transfer |
| up_ready | output | 1 | Transfer accepted or completed this cycle |
| up_addr | input | ADDR_W | Transfer byte address |
| up_write | input | 1 | 1 for write, 0 for read |
| up_nonsec | input | 1 | Security attribute of the transfer, 1 for non-secure |
| up_err | output | 1 | Blocked transfer completes with an error |
| up_razwi | output | 1 | Blocked transfer completes quietly (read zero, write dropped) |
| dn_valid | output | 1 | Forwarded transfer toward memory |
| dn_ready | input | 1 | Memory accepts the forwarded transfer |
| dn_addr | output | ADDR_W | Forwarded address |
| dn_write | output | 1 | Forwarded direction |
| cfg_we | input | 1 | Register write strobe |
| cfg_re | input | 1 | Register read strobe (advances the index on DATA) |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational |
| irq | output | 1 | Violation interrupt |

## Verification
The hardest state to reach is a gate request made while a forwarded transfer is stuck behind a low `dn_ready`. The acknowledge must wait for that transfer to finish, and only then may the hold response release a blocked transfer. The bench holds `dn_ready` low under a pending legal transfer, sets the request, and confirms that the acknowledge stays low. It then frees downstream and watches the acknowledge rise. Next it presents a violating transfer in hold mode and clears the request, checking that the transfer stays stalled until the clock after the release.

// File: rtl/secblk_pkg.sv
package secblk_pkg;

  typedef enum logic [1:0] {
    RSP_RAZWI   = 2'd0,
    RSP_ERR     = 2'd1,
    RSP_HOLD    = 2'd2,
    RSP_ERR_ALT = 2'd3
  } rsp_mode_e;

  localparam logic [2:0] REG_CTRL  = 3'd0;
  localparam logic [2:0] REG_INFO  = 3'd1;
  localparam logic [2:0] REG_INDEX = 3'd2;
  localparam logic [2:0] REG_DATA  = 3'd3;
  localparam logic [2:0] REG_IRQ   = 3'd4;
  localparam logic [2:0] REG_CAPT  = 3'd5;

  // Sum of the first n 16-bit block counts packed in v (up to 8 ranges).
  function automatic int unsigned blk_sum(input logic [127:0] v, input int unsigned n);
    int unsigned s;
    s = 0;
    for (int i = 0; i < 8; i++) begin
      if (i < n) s += 32'(v[i*16 +: 16]);
    end
    return s;
  endfunction

endpackage

// File: rtl/secblk_map.sv
module secblk_map #(
  parameter int ADDR_W     = 16,
  parameter int BLK_SHIFT  = 8,
  parameter int NUM_RANGES = 2,
  parameter int IDXB_W     = 6,
  parameter logic [NUM_RANGES*ADDR_W-1:0] RANGE_BASE = {16'h8000, 16'h0000},
  parameter logic [NUM_RANGES*16-1:0]     RANGE_BLKS = {16'd32, 16'd32}
) (
  input  logic [ADDR_W-1:0]     addr,
  output logic [NUM_RANGES-1:0] hit_vec,
  output logic [IDXB_W-1:0]     blk_idx
);
  import secblk_pkg::*;

  logic [31:0]       a32;
  logic [IDXB_W-1:0] rel [NUM_RANGES];

  assign a32 = 32'(addr);

  for (genvar r = 0; r < NUM_RANGES; r++) begin : g_rng
    localparam int unsigned RB  = 32'(RANGE_BASE[r*ADDR_W +: ADDR_W]);
    localparam int unsigned RN  = 32'(RANGE_BLKS[r*16 +: 16]);
    localparam int unsigned OFF = blk_sum(128'(RANGE_BLKS), r);
    assign hit_vec[r] = (a32 >= RB) && (a32 < RB + (RN << BLK_SHIFT));
    assign rel[r]     = IDXB_W'(OFF + ((a32 - RB) >> BLK_SHIFT));
  end

  always_comb begin
    blk_idx = '0;
    for (int r = NUM_RANGES - 1; r >= 0; r--) begin
      if (hit_vec[r]) blk_idx = rel[r];
    end
  end

endmodule

// File: rtl/secblk_lut.sv
module secblk_lut #(
  parameter int NWORDS = 2,
  parameter int IDXB_W = 6,
  localparam int WIDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock,
  input  logic              idx_we,
  input  logic              data_we,
  input  logic              data_re,
  input  logic [31:0]       wdata,
  input  logic [IDXB_W-1:0] look_idx,
  output logic              look_bit,
  output logic [WIDX_W-1:0] idx_q,
  output logic [31:0]       rdata
);

  logic [NWORDS*32-1:0] bits_q;
  logic                 step;
  logic [WIDX_W-1:0]    idx_nxt;

  assign look_bit = bits_q[look_idx];
  assign rdata    = bits_q[idx_q*32 +: 32];
  assign step     = data_re | (data_we & ~lock);
  assign idx_nxt  = (32'(idx_q) == NWORDS - 1) ? '0 : idx_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
      idx_q  <= '0;
    end else begin
      if (data_we && !lock) bits_q[idx_q*32 +: 32] <= wdata;
      if (idx_we && !lock)  idx_q <= WIDX_W'(wdata);
      else if (step)        idx_q <= idx_nxt;
    end
  end

  // R5
  lut_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lock) |-> $stable(bits_q));

endmodule

// File: rtl/secblk_gate.sv
module secblk_gate #(
  parameter bit GATE_EN = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic busy,
  output logic ack
);

  if (GATE_EN) begin : g_gate
    logic ack_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ack_q <= 1'b0;
      else        ack_q <= req & (ack_q | ~busy);
    end
    assign ack = ack_q;

    // R4
    ack_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> $past(req));
  end else begin : g_nogate
    assign ack = 1'b0;
  end

endmodule

// File: rtl/secblk_guard.sv
module secblk_guard #(
  parameter int ADDR_W     = 16,
  parameter int BLK_SHIFT  = 8,
  parameter int NUM_RANGES = 2,
  parameter logic [NUM_RANGES*ADDR_W-1:0] RANGE_BASE = {16'h8000, 16'h0000},
  parameter logic [NUM_RANGES*16-1:0]     RANGE_BLKS = {16'd32, 16'd32},
  parameter bit GATE_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic              up_write,
  input  logic              up_nonsec,
  output logic              up_err,
  output logic              up_razwi,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [ADDR_W-1:0] dn_addr,
  output logic              dn_write,
  input  logic              cfg_we,
  input  logic              cfg_re,
  input  logic [2:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              irq
);
  import secblk_pkg::*;

  localparam int TOTAL_BLKS = blk_sum(128'(RANGE_BLKS), NUM_RANGES);
  localparam int NWORDS     = (TOTAL_BLKS + 31) / 32;
  localparam int IDXB_W     = (TOTAL_BLKS > 1) ? $clog2(TOTAL_BLKS) : 1;
  localparam int WIDX_W     = (NWORDS > 1) ? $clog2(NWORDS) : 1;

  logic [NUM_RANGES-1:0] hit_vec;
  logic [IDXB_W-1:0]     blk_idx;
  logic                  blk_ns;
  logic [WIDX_W-1:0]     lut_idx;
  logic [31:0]           lut_rdata;
  logic                  gate_ack;

  logic      irq_en_q, gate_req_q, lock_q, irq_stat_q;
  rsp_mode_e mode_q;
  logic [31:0] capt_q;

  logic viol, held, is_err, viol_evt, fwd_busy, ctrl_wr, irq_clr;

  secblk_map #(
    .ADDR_W(ADDR_W), .BLK_SHIFT(BLK_SHIFT), .NUM_RANGES(NUM_RANGES),
    .IDXB_W(IDXB_W), .RANGE_BASE(RANGE_BASE), .RANGE_BLKS(RANGE_BLKS)
  ) u_map (
    .addr(up_addr), .hit_vec(hit_vec), .blk_idx(blk_idx)
  );

  secblk_lut #(.NWORDS(NWORDS), .IDXB_W(IDXB_W)) u_lut (
    .clk(clk), .rst_n(rst_n), .lock(lock_q),
    .idx_we(cfg_we && cfg_addr == REG_INDEX),
    .data_we(cfg_we && cfg_addr == REG_DATA),
    .data_re(cfg_re && cfg_addr == REG_DATA),
    .wdata(cfg_wdata), .look_idx(blk_idx), .look_bit(blk_ns),
    .idx_q(lut_idx), .rdata(lut_rdata)
  );

  secblk_gate #(.GATE_EN(GATE_EN)) u_gate (
    .clk(clk), .rst_n(rst_n), .req(gate_req_q), .busy(fwd_busy), .ack(gate_ack)
  );

  // Transfer path
  assign viol     = up_valid & (~(|hit_vec) | (blk_ns != up_nonsec));
  assign is_err   = (mode_q == RSP_ERR) || (mode_q == RSP_ERR_ALT);
  assign held     = viol & (mode_q == RSP_HOLD) & gate_req_q;
  assign viol_evt = viol & ~gate_ack;
  assign fwd_busy = up_valid & ~viol & ~dn_ready;

  assign dn_valid = up_valid & ~viol & ~gate_ack;
  assign up_ready = ~gate_ack & (viol ? ~held : dn_ready);
  assign up_err   = viol_evt & is_err;
  assign up_razwi = viol_evt & ~is_err & ~held;
  assign dn_addr  = up_addr;
  assign dn_write = up_write;

  // Control register
  assign ctrl_wr = cfg_we && !lock_q && cfg_addr == REG_CTRL;
  assign irq_clr = cfg_we && cfg_addr == REG_IRQ && cfg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en_q   <= 1'b0;
      mode_q     <= RSP_RAZWI;
      gate_req_q <= 1'b0;
      lock_q     <= 1'b0;
    end else if (ctrl_wr) begin
      irq_en_q   <= cfg_wdata[0];
      mode_q     <= rsp_mode_e'(cfg_wdata[2:1]);
      gate_req_q <= cfg_wdata[3] & GATE_EN;
      lock_q     <= cfg_wdata[4];
    end
  end

  // Violation status and capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_stat_q <= 1'b0;
      capt_q     <= '0;
    end else begin
      if (viol_evt)     irq_stat_q <= 1'b1;
      else if (irq_clr) irq_stat_q <= 1'b0;
      if (viol_evt && !irq_stat_q)
        capt_q <= 32'(up_addr) | (32'(up_write) << 31);
    end
  end

  assign irq = irq_stat_q & irq_en_q;

  always_comb begin
    case (cfg_addr)
      REG_CTRL:  cfg_rdata = {25'd0, 1'(GATE_EN), gate_ack, lock_q, gate_req_q,
                              mode_q, irq_en_q};
      REG_INFO:  cfg_rdata = 32'd1 << BLK_SHIFT;
      REG_INDEX: cfg_rdata = 32'(lut_idx);
      REG_DATA:  cfg_rdata = lut_rdata;
      REG_IRQ:   cfg_rdata = {31'd0, irq_stat_q};
      REG_CAPT:  cfg_rdata = capt_q;
      default:   cfg_rdata = '0;
    endcase
  end

  // R2
  range_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  // R4
  gate_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_ack |-> (!dn_valid && !up_ready));
  // R5
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lock_q) |-> lock_q);
  // R6
  stat_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_stat_q) |-> $past(viol_evt));
  // R7
  capt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_stat_q && $past(irq_stat_q)) |-> $stable(capt_q));
  // R10
  fwd_handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && dn_ready) |-> up_ready);

endmodule

// File: tb/test_secblk_guard.sv
module test_secblk_guard;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        up_valid = 1'b0, up_write = 1'b0, up_nonsec = 1'b0;
  logic [15:0] up_addr = '0;
  logic        dn_ready = 1'b1;
  logic        cfg_we = 1'b0, cfg_re = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        up_ready, up_err, up_razwi, dn_valid, dn_write, irq;
  logic [15:0] dn_addr;
  logic [31:0] cfg_rdata;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  secblk_guard i_secblk_guard (
    .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_ready(up_ready),
    .up_addr(up_addr), .up_write(up_write), .up_nonsec(up_nonsec),
    .up_err(up_err), .up_razwi(up_razwi), .dn_valid(dn_valid),
    .dn_ready(dn_ready), .dn_addr(dn_addr), .dn_write(dn_write),
    .cfg_we(cfg_we), .cfg_re(cfg_re), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq(irq)
  );

  typedef struct packed {
    logic [15:0] addr;
    logic        wr;
    logic        ns;
    logic        pass;
  } vec_t;

  // Table: word0 = 0x000000F0 (blocks 4..7 non-secure), word1 = 0x80000001.
  localparam vec_t VECS [11] = '{
    '{16'h0000, 1'b0, 1'b0, 1'b1},
    '{16'h0400, 1'b0, 1'b1, 1'b1},
    '{16'h0400, 1'b0, 1'b0, 1'b0},
    '{16'h07FF, 1'b1, 1'b1, 1'b1},
    '{16'h0800, 1'b0, 1'b1, 1'b0},
    '{16'h8000, 1'b0, 1'b1, 1'b1},
    '{16'h8100, 1'b0, 1'b1, 1'b0},
    '{16'h9F00, 1'b1, 1'b1, 1'b1},
    '{16'h9EFF, 1'b0, 1'b0, 1'b1},
    '{16'h4000, 1'b0, 1'b0, 1'b0},
    '{16'hA000, 1'b0, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_re = 1'b1; cfg_addr = a;
    #1 d = cfg_rdata;
    @(negedge clk);
    cfg_re = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] d;
    cfg_read(a, d);
    chk(req, d, exp);
  endtask

  // Present a transfer at a negedge and check the combinational response.
  task automatic present(input string req, input logic [15:0] a, input logic w,
                         input logic ns, input logic [3:0] exp);
    @(negedge clk);
    up_valid = 1'b1; up_addr = a; up_write = w; up_nonsec = ns;
    #1 chk(req, {28'd0, up_ready, dn_valid, up_err, up_razwi}, {28'd0, exp});
  endtask

  task automatic idle();
    @(negedge clk);
    up_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state
    rd_chk("R9 ctrl", 3'd0, 32'h40);
    rd_chk("R9 block size", 3'd1, 32'd256);
    rd_chk("R9 status", 3'd4, 32'd0);
    chk("R9 irq pin", {31'd0, irq}, 32'd0);
    present("R9 all secure", 16'h0400, 1'b0, 1'b0, 4'b1100);
    idle();

    // R8 table fill and auto-increment
    cfg_write(3'd2, 32'd0);
    cfg_write(3'd3, 32'h0000_00F0);
    cfg_write(3'd3, 32'h8000_0001);
    rd_chk("R8 index wraps", 3'd2, 32'd0);
    rd_chk("R8 word0", 3'd3, 32'h0000_00F0);
    rd_chk("R8 word1", 3'd3, 32'h8000_0001);
    rd_chk("R8 index after reads", 3'd2, 32'd0);

    // R1 R2 R3 vector walk, error mode, irq enabled
    cfg_write(3'd0, 32'h3);
    for (int i = 0; i < 11; i++) begin
      present($sformatf("R1 R2 R3 vec%0d", i), VECS[i].addr, VECS[i].wr, VECS[i].ns,
              VECS[i].pass ? 4'b1100 : 4'b1010);
    end
    idle();

    // R6 R7 status and capture of the first violation
    rd_chk("R6 status set", 3'd4, 32'd1);
    chk("R6 irq pin", {31'd0, irq}, 32'd1);
    rd_chk("R7 capture first", 3'd5, 32'h0000_0400);
    cfg_write(3'd4, 32'd1);
    rd_chk("R6 status cleared", 3'd4, 32'd0);
    chk("R6 irq low", {31'd0, irq}, 32'd0);

    // R3 R10 quiet mode, irq disabled, downstream stalled
    cfg_write(3'd0, 32'h0);
    dn_ready = 1'b0;
    present("R3 R10 razwi", 16'h0800, 1'b1, 1'b1, 4'b1001);
    idle();
    rd_chk("R6 status no pin", 3'd4, 32'd1);
    chk("R6 pin disabled", {31'd0, irq}, 32'd0);
    rd_chk("R7 capture write", 3'd5, 32'h8000_0800);
    cfg_write(3'd4, 32'd1);

    // R4 R10 gating held off by a stalled forwarded transfer
    present("R10 fwd waits", 16'h0000, 1'b0, 1'b0, 4'b0100);
    cfg_write(3'd0, 32'h8);
    repeat (2) @(negedge clk);
    rd_chk("R4 ack held off", 3'd0, 32'h48);
    @(negedge clk);
    dn_ready = 1'b1;
    @(negedge clk);
    up_valid = 1'b0;
    rd_chk("R4 ack set", 3'd0, 32'h68);
    present("R4 gated legal", 16'h0000, 1'b0, 1'b0, 4'b0000);
    idle();

    // R3 R4 hold mode released by clearing the request
    cfg_write(3'd0, 32'hC);
    present("R3 hold stalls", 16'h0400, 1'b0, 1'b0, 4'b0000);
    cfg_write(3'd0, 32'h4);
    @(negedge clk);
    #1 chk("R3 R4 released", {28'd0, up_ready, dn_valid, up_err, up_razwi}, 32'b1001);
    idle();

    // R5 lockdown
    cfg_write(3'd4, 32'd1);
    cfg_write(3'd0, 32'h12);
    rd_chk("R5 locked", 3'd0, 32'h52);
    cfg_write(3'd0, 32'h0);
    rd_chk("R5 ctrl frozen", 3'd0, 32'h52);
    cfg_write(3'd2, 32'd1);
    rd_chk("R5 index frozen", 3'd2, 32'd0);
    cfg_write(3'd3, 32'hFFFF_FFFF);
    rd_chk("R5 table frozen", 3'd3, 32'h0000_00F0);
    present("R5 mode kept", 16'h0400, 1'b0, 1'b0, 4'b1010);
    idle();
    rd_chk("R5 status set", 3'd4, 32'd1);
    cfg_write(3'd4, 32'd1);
    rd_chk("R5 clear while locked", 3'd4, 32'd0);

    // R5 R9 reset clears lock and table
    do_reset();
    rd_chk("R5 lock cleared", 3'd0, 32'h40);
    rd_chk("R9 table cleared", 3'd3, 32'd0);

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule